// File: doc/BRIEF.md
# Scan Result Buffer with End-of-Conversion and Window Watchdog

This block sits behind a converter sequencer and gathers conversion results. Each result arrives as a data word with a slot number and a one-cycle valid strobe. In the multi-slot modes, which are scan and buffered continuous, the result is written into the matching register of a bank of numbered slots. In every mode the newest result is also kept in a single last-result register. Software reads the whole bank and the last-result register directly.

Two sticky status flags record events. The end-of-conversion flag is set after every result in single-result mode. In the multi-slot modes it is set only once a full set of slot writes has arrived. The watchdog flag is set when a result reaches the high threshold or the low threshold. Each flag has its own interrupt enable, and a single interrupt line combines the enabled flags. Software clears each flag with a one-cycle strobe.

Top module: `scanbuf_top`

## Requirements
- R1: During reset and after it, every slot register, the last-result register, both flags and `irq` read 0.
- R2: Every valid result, in any mode, appears on `last_q` in the cycle after its strobe.
- R3: In scan mode (`mode`=01) or buffered mode (`mode`=10), a valid result whose slot number k lies in 1..NSLOT is written to `buf_flat[(k-1)*DATA_W +: DATA_W]`, and all other slots keep their values.
- R4: In single-result mode (`mode`=00, and `mode`=11 behaves the same way), valid results leave every slot register unchanged.
- R5: A result with slot number 0, or with a slot number above NSLOT, writes no slot and does not count towards filling the bank. It still updates `last_q` and the watchdog.
- R6: In single-result mode, every valid result sets `eoc_flag` in the next cycle.
- R7: In scan or buffered mode, `eoc_flag` is set after the NSLOT-th in-range result of a sequence and not before it. The fill count then returns to zero, so the next sequence again needs NSLOT results. Single-result mode holds the count at zero.
- R8: `awd_flag` is set in the cycle after a valid result that satisfies `res_data >= thr_hi` or `res_data <= thr_lo` (unsigned compare, equality included). A result strictly between the two thresholds does not set it.
- R9: Both flags are set whatever the state of their enables, and they stay set until their clear strobe (`eoc_clr`, `awd_clr`) is high at a clock edge. When a set event and a clear arrive in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when (`eoc_flag` and `eoc_ie`) or (`awd_flag` and `awd_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 2 | 00 single-result, 01 scan, 10 buffered continuous, 11 treated as single-result |
| res_valid | input | 1 | One-cycle strobe: result present |
| res_data | input | DATA_W | Conversion result |
| res_slot | input | SLOT_W | Slot number of the result, 1..NSLOT |
| thr_hi | input | DATA_W | High watchdog threshold |
| thr_lo | input | DATA_W | Low watchdog threshold |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| awd_ie | input | 1 | Watchdog interrupt enable |
| eoc_clr | input | 1 | Clear strobe for the end-of-conversion flag |
| awd_clr | input | 1 | Clear strobe for the watchdog flag |
| buf_flat | output | NSLOT*DATA_W | All slot registers; slot k occupies bits (k-1)*DATA_W upward |
| last_q | output | DATA_W | Most recent result |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| awd_flag | output | 1 | Sticky watchdog flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the exact point at which the bank is full. A wrong count would raise the end-of-conversion flag one result early or one result late, or would fail to restart the next sequence at zero. The stimulus therefore runs a complete scan of NSLOT results with a slot-0 result inserted partway through. It then runs a second complete sequence in buffered mode with different data, and the scoreboard checks the flag after every single result. The same-cycle set-and-clear collision is produced by raising a clear strobe in the cycle of a valid result.

// File: rtl/scanbuf_pkg.sv
package scanbuf_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_BUFCNT = 2'b10,
    MODE_ALT    = 2'b11
  } mode_e;

  function automatic logic is_multi(input logic [1:0] m);
    return (m == MODE_SCAN) || (m == MODE_BUFCNT);
  endfunction
endpackage

// File: rtl/scanbuf_slots.sv
module scanbuf_slots #(
  parameter int DATA_W = 10,
  parameter int NSLOT  = 15,
  parameter int SLOT_W = $clog2(NSLOT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NSLOT*DATA_W-1:0] bank
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] q, d;

    always_comb begin
      hit = wr_en && (wr_slot == SLOT_W'(i + 1));
      d   = hit ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign bank[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/scanbuf_fill.sv
module scanbuf_fill #(
  parameter int NSLOT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic multi,
  input  logic valid,
  input  logic in_range,
  output logic eoc_evt
);
  localparam int CNT_W = $clog2(NSLOT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_one;

  always_comb begin
    last_one = (cnt_q == CNT_W'(NSLOT - 1));
    cnt_d    = cnt_q;
    if (!multi)
      cnt_d = '0;
    else if (valid && in_range)
      cnt_d = last_one ? '0 : cnt_q + 1'b1;
    eoc_evt = valid && (!multi || (in_range && last_one));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scanbuf_watch.sv
module scanbuf_watch #(
  parameter int DATA_W = 10
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  output logic              alert
);
  always_comb alert = valid && ((data >= hi) || (data <= lo));
endmodule

// File: rtl/scanbuf_flag.sv
module scanbuf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d;
  always_comb d = set | (q & ~clr);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/scanbuf_top.sv
module scanbuf_top #(
  parameter int DATA_W = 10,
  parameter int NSLOT  = 15,
  parameter int SLOT_W = $clog2(NSLOT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    res_valid,
  input  logic [DATA_W-1:0]       res_data,
  input  logic [SLOT_W-1:0]       res_slot,
  input  logic [DATA_W-1:0]       thr_hi,
  input  logic [DATA_W-1:0]       thr_lo,
  input  logic                    eoc_ie,
  input  logic                    awd_ie,
  input  logic                    eoc_clr,
  input  logic                    awd_clr,
  output logic [NSLOT*DATA_W-1:0] buf_flat,
  output logic [DATA_W-1:0]       last_q,
  output logic                    eoc_flag,
  output logic                    awd_flag,
  output logic                    irq
);
  import scanbuf_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic multi, in_range, slot_we, eoc_evt, awd_evt;
  logic [DATA_W-1:0] last_d;

  always_comb begin
    multi    = is_multi(mode);
    in_range = (res_slot != '0) && (res_slot <= SLOT_W'(NSLOT));
    slot_we  = res_valid && multi && in_range;
    last_d   = res_valid ? res_data : last_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) last_q <= '0;
    else             last_q <= last_d;
  end

  scanbuf_slots #(.DATA_W(DATA_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(slot_we), .wr_slot(res_slot),
    .wr_data(res_data), .bank(buf_flat)
  );

  scanbuf_fill #(.NSLOT(NSLOT)) u_fill (
    .clk(clk), .rst_n(rst_sync_n), .multi(multi), .valid(res_valid),
    .in_range(in_range), .eoc_evt(eoc_evt)
  );

  scanbuf_watch #(.DATA_W(DATA_W)) u_watch (
    .valid(res_valid), .data(res_data), .hi(thr_hi), .lo(thr_lo), .alert(awd_evt)
  );

  scanbuf_flag u_eoc (.clk(clk), .rst_n(rst_sync_n), .set(eoc_evt), .clr(eoc_clr), .q(eoc_flag));
  scanbuf_flag u_awd (.clk(clk), .rst_n(rst_sync_n), .set(awd_evt), .clr(awd_clr), .q(awd_flag));

  always_comb irq = (eoc_flag & eoc_ie) | (awd_flag & awd_ie);
endmodule

// File: rtl/scanbuf_chk.sv
module scanbuf_chk #(
  parameter int DATA_W = 10,
  parameter int NSLOT  = 15,
  parameter int SLOT_W = $clog2(NSLOT + 1)
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic [1:0]              mode,
  input logic                    res_valid,
  input logic [DATA_W-1:0]       res_data,
  input logic [DATA_W-1:0]       thr_hi,
  input logic [DATA_W-1:0]       thr_lo,
  input logic                    eoc_clr,
  input logic                    awd_clr,
  input logic [NSLOT*DATA_W-1:0] buf_flat,
  input logic [DATA_W-1:0]       last_q,
  input logic                    eoc_flag,
  input logic                    awd_flag,
  input logic                    irq
);
  import scanbuf_pkg::*;

  assert_last_follows_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_valid |=> last_q == $past(res_data));

  assert_single_keeps_bank_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && !is_multi(mode)) |=> $stable(buf_flat));

  assert_single_sets_eoc_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && !is_multi(mode)) |=> eoc_flag);

  assert_no_eoc_without_result_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_valid |=> !$rose(eoc_flag));

  assert_threshold_alert_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid && (res_data >= thr_hi || res_data <= thr_lo)) |=> awd_flag);

  assert_eoc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eoc_flag && !eoc_clr) |=> eoc_flag);

  assert_awd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (awd_flag && !awd_clr) |=> awd_flag);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!eoc_flag && !awd_flag) |-> !irq);
endmodule

bind scanbuf_top scanbuf_chk #(.DATA_W(DATA_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode(mode), .res_valid(res_valid),
  .res_data(res_data), .thr_hi(thr_hi), .thr_lo(thr_lo), .eoc_clr(eoc_clr),
  .awd_clr(awd_clr), .buf_flat(buf_flat), .last_q(last_q), .eoc_flag(eoc_flag),
  .awd_flag(awd_flag), .irq(irq)
);

// File: tb/sim_scanbuf_top.sv
module sim_scanbuf_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int NS = 15;
  localparam int SW = $clog2(NS + 1);
  localparam int WATCHDOG = 20000;

  typedef struct {
    logic [DW-1:0]    last;
    logic [NS*DW-1:0] bank;
    logic             eoc;
    logic             awd;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic res_valid;
  logic [DW-1:0] res_data, thr_hi, thr_lo;
  logic [SW-1:0] res_slot;
  logic eoc_ie, awd_ie, eoc_clr, awd_clr;
  logic [NS*DW-1:0] buf_flat;
  logic [DW-1:0] last_q;
  logic eoc_flag, awd_flag, irq;

  int n_chk = 0, n_bad = 0;
  item_t q[$];
  logic [DW-1:0] mbank [NS];
  int  mcnt = 0;
  logic meoc = 1'b0, mawd = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanbuf_top #(.DATA_W(DW), .NSLOT(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .res_valid(res_valid), .res_data(res_data),
    .res_slot(res_slot), .thr_hi(thr_hi), .thr_lo(thr_lo), .eoc_ie(eoc_ie),
    .awd_ie(awd_ie), .eoc_clr(eoc_clr), .awd_clr(awd_clr), .buf_flat(buf_flat),
    .last_q(last_q), .eoc_flag(eoc_flag), .awd_flag(awd_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [NS*DW-1:0] act,
                       input logic [NS*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NS*DW-1:0] flat_model();
    logic [NS*DW-1:0] f;
    for (int i = 0; i < NS; i++) f[i*DW +: DW] = mbank[i];
    return f;
  endfunction

  // driver: applies one result and pushes the expected outcome
  task automatic send(input logic [DW-1:0] d, input logic [SW-1:0] s, input string tag,
                      input logic with_clr = 1'b0);
    item_t it;
    bit multi = (mode == 2'b01) || (mode == 2'b10);
    bit inr = (s != 0) && (s <= NS);
    if (with_clr) meoc = 1'b0;
    if (multi && inr) begin
      mbank[s-1] = d;
      mcnt++;
      if (mcnt == NS) begin meoc = 1'b1; mcnt = 0; end
    end else if (!multi) begin
      meoc = 1'b1; mcnt = 0;
    end
    if (d >= thr_hi || d <= thr_lo) mawd = 1'b1;
    it.last = d; it.bank = flat_model(); it.eoc = meoc; it.awd = mawd; it.tag = tag;
    q.push_back(it);
    res_data = d; res_slot = s; res_valid = 1'b1; eoc_clr = with_clr;
    @(negedge clk);
    res_valid = 1'b0; eoc_clr = 1'b0;
  endtask

  // monitor: pops an expected item one edge after each accepted result
  initial begin
    forever begin
      bit seen;
      @(posedge clk);
      seen = res_valid;
      @(negedge clk);
      if (seen) begin
        item_t it;
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected result", 0, 0);
        end else begin
          it = q.pop_front();
          check(last_q == it.last, {"R2 last ", it.tag}, last_q, it.last);
          check(buf_flat == it.bank, {"R3 R4 R5 bank ", it.tag}, buf_flat, it.bank);
          check(eoc_flag == it.eoc, {"R6 R7 R9 eoc ", it.tag}, eoc_flag, it.eoc);
          check(awd_flag == it.awd, {"R8 awd ", it.tag}, awd_flag, it.awd);
        end
      end
    end
  end

  task automatic clear_flags(input bit ce, input bit ca);
    eoc_clr = ce; awd_clr = ca;
    @(negedge clk);
    eoc_clr = 1'b0; awd_clr = 1'b0;
    if (ce) meoc = 1'b0;
    if (ca) mawd = 1'b0;
    check(eoc_flag == meoc, "R9 eoc after clear", eoc_flag, meoc);
    check(awd_flag == mawd, "R9 awd after clear", awd_flag, mawd);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) mbank[i] = '0;
    rst_n = 1'b0; mode = 2'b00; res_valid = 1'b0; res_data = '0; res_slot = '0;
    thr_hi = 10'd800; thr_lo = 10'd100; eoc_ie = 1'b0; awd_ie = 1'b0;
    eoc_clr = 1'b0; awd_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(buf_flat == '0 && last_q == '0, "R1 data in reset", {buf_flat, last_q}, 0);
    check(!eoc_flag && !awd_flag && !irq, "R1 flags in reset", {eoc_flag, awd_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(buf_flat == '0 && last_q == '0 && !irq, "R1 after release", buf_flat, 0);

    // single-result mode
    send(10'd500, 4'd3, "single");
    check(irq == 1'b0, "R10 enables off", irq, 0);
    eoc_ie = 1'b1; #1;
    check(irq == 1'b1, "R10 eoc enabled", irq, 1);
    clear_flags(1'b1, 1'b0);
    check(irq == 1'b0, "R10 after eoc clear", irq, 0);
    send(10'd800, 4'd0, "hi equal R8");
    clear_flags(1'b1, 1'b1);
    send(10'd100, 4'd1, "lo equal R8");
    awd_ie = 1'b1; eoc_ie = 1'b0; #1;
    check(irq == 1'b1, "R10 awd enabled", irq, 1);
    clear_flags(1'b1, 1'b1);
    send(10'd101, 4'd2, "inside lo R8");
    send(10'd799, 4'd2, "inside hi R8");
    send(10'd1023, 4'd7, "above hi R8");
    clear_flags(1'b1, 1'b1);
    send(10'd300, 4'd5, "set wins over clear R9", 1'b1);
    clear_flags(1'b1, 1'b0);

    // scan mode: full sequence with a slot-0 result inserted
    mode = 2'b01; mcnt = 0;
    for (int k = 1; k <= NS; k++) begin
      send(DW'(200 + k), SW'(k), "scan R3 R7");
      if (k == 7) send(10'd333, 4'd0, "scan slot0 R5");
    end
    clear_flags(1'b1, 1'b0);

    // buffered mode: second sequence, new data, reversed order
    mode = 2'b10;
    for (int k = NS; k >= 1; k--) send(DW'(400 + 3*k), SW'(k), "buffered R3 R7");
    send(10'd555, 4'd4, "buffered restart R7");
    clear_flags(1'b1, 1'b0);
    mode = 2'b11;
    send(10'd600, 4'd9, "alt mode R4 R6");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 all results seen", q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule